// File: doc/BRIEF.md
# Flash Busy Status Read-Back Generator

This block produces the data a parallel NOR-style flash returns on reads while an internal program or erase operation runs. The command decoder tells it when an operation starts and which kind it is, along with the plane and sector it targets and, for a program, the address and data word being written. It then records whether the device is idle, programming, erasing or erase-suspended. On every read it either passes the array word through or replaces it with status bits. Those status bits are an inverted bit 7 at the location being programmed, a bit 6 that flips on each read from the busy plane, and a bit 2 that flips on each read from the suspended sector.

The block also drives the enable of an open-drain ready/busy line. The line is pulled low for the whole internal operation and released otherwise, so that several devices can share one line. The flash array and the command decoder are outside this block. The array word arrives on `arrayData`, and operation start, completion, suspend and resume arrive as single-cycle strobes.

Top module: `flash_poll_status`

## Requirements
- R1: During a program, a read from the busy plane returns bit 7 set to the complement of bit 7 of the loaded data when `rdAddr` equals the loaded address, and bit 7 set to 0 at any other address. In both cases every bit except 6 and 7 is 0.
- R2: During an erase, a read from the busy plane returns 0 on bit 7 and 0 on every bit except bit 6.
- R3: During a program or erase, bit 6 of a read from the busy plane alternates on successive reads of that plane. The first read after an operation starts returns 0, and the alternation continues across a suspend and resume.
- R4: While erase-suspended, a read whose plane and sector match the suspended erase returns the array word with bit 2 replaced by a flip-flop. That flip-flop starts at 0 on suspend entry and inverts on each such read. Reads from any other sector return the array word unchanged.
- R5: When the block is idle, and from the cycle after `opDone`, reads return `arrayData` exactly, with no bit toggling.
- R6: `rdyBusyOe` is 1 from the cycle after an accepted `opStart` until the cycle after `opDone` or `suspendReq`. It is 1 again after `resumeReq`, and it is 0 after reset, while idle and while suspended.
- R7: A read issued in the first cycle after `opStart` already returns status. No settling delay is needed.
- R8: A read is the rising edge of `rdStrobe`. `rdData` updates on the clock edge that sees the rise and holds otherwise. Holding `rdStrobe` high does not advance any toggle.
- R9: While busy, a read from a plane other than the busy plane returns `arrayData` unchanged and does not advance the busy plane's toggle.
- R10: `opStart` is ignored unless the block is idle. The operation kind, address and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStart | input | 1 | Start strobe for an internal operation |
| opErase | input | 1 | Operation kind at start: 1 erase, 0 program |
| opPlane | input | PLANE_W | Plane of the operation |
| opSector | input | SECTOR_W | Sector of the operation |
| opAddr | input | ADDR_W | Address being programmed |
| opData | input | DATA_W | Data word being programmed |
| opDone | input | 1 | Completion strobe for the running operation |
| suspendReq | input | 1 | Erase suspend strobe |
| resumeReq | input | 1 | Erase resume strobe |
| rdStrobe | input | 1 | Read strobe; its rising edge is a read |
| rdPlane | input | PLANE_W | Plane of the read |
| rdSector | input | SECTOR_W | Sector of the read |
| rdAddr | input | ADDR_W | Address of the read |
| arrayData | input | DATA_W | Word from the flash array |
| rdData | output | DATA_W | Read data returned to the host |
| rdyBusyOe | output | 1 | 1 pulls the shared ready/busy line low |

## Verification
A corrupted operation state shows up on the very next read: either bit 7 and the zeroed low bits appear where array data should be, or array data appears where status should be. The same fault also shows on `rdyBusyOe` one cycle after the strobe that should have moved the state. A toggle flip-flop that is missed or advanced twice is only visible on the following read of the same plane or sector. For that reason the stimulus reads each target several times in a row, mixes in reads from other planes and sectors, and holds the read strobe high to expose double counting.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2,
    ST_SUSP  = 2'd3
  } opState_t;

  typedef struct packed {
    logic loadOp;      // capture operation target at an accepted start
    logic clrToggles;  // reset every plane's bit-6 toggle
    logic clrSusp;     // reset the bit-2 toggle at suspend entry
    logic readEvt;     // rising edge of the read strobe
  } ctrlStrobe_t;
endpackage

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opStart,
  input  logic        opErase,
  input  logic        opDone,
  input  logic        suspendReq,
  input  logic        resumeReq,
  input  logic        rdStrobe,
  output opState_t    state,
  output ctrlStrobe_t strobe,
  output logic        rdyBusyOe
);
  opState_t nextState;
  logic     rdPrev;

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.readEvt = rdStrobe & ~rdPrev;
    unique case (state)
      ST_IDLE: if (opStart) begin
        nextState         = opErase ? ST_ERASE : ST_PROG;
        strobe.loadOp     = 1'b1;
        strobe.clrToggles = 1'b1;
      end
      ST_PROG: if (opDone) nextState = ST_IDLE;
      ST_ERASE: begin
        if (opDone) nextState = ST_IDLE;
        else if (suspendReq) begin
          nextState      = ST_SUSP;
          strobe.clrSusp = 1'b1;
        end
      end
      ST_SUSP: if (resumeReq) nextState = ST_ERASE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rdPrev <= 1'b0;
    end else begin
      state  <= nextState;
      rdPrev <= rdStrobe;
    end
  end

  assign rdyBusyOe = (state == ST_PROG) || (state == ST_ERASE);
endmodule

// File: rtl/flash_poll_datapath.sv
module flash_poll_datapath
  import flash_poll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int NUM_PLANES = 4,
  parameter int SECTOR_W   = 4,
  localparam int PLANE_W   = $clog2(NUM_PLANES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  opState_t            state,
  input  ctrlStrobe_t         strobe,
  input  logic [PLANE_W-1:0]  opPlane,
  input  logic [SECTOR_W-1:0] opSector,
  input  logic [ADDR_W-1:0]   opAddr,
  input  logic [DATA_W-1:0]   opData,
  input  logic [PLANE_W-1:0]  rdPlane,
  input  logic [SECTOR_W-1:0] rdSector,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   arrayData,
  output logic [DATA_W-1:0]   rdData,
  output logic [PLANE_W-1:0]  busyPlane,
  output logic [ADDR_W-1:0]   lastAddr,
  output logic [DATA_W-1:0]   lastData
);
  logic [SECTOR_W-1:0]   busySector;
  logic [NUM_PLANES-1:0] togPlane;
  logic                  togSusp;
  logic                  inBusy, hitPlane, hitSector;
  logic [DATA_W-1:0]     readVal;

  assign inBusy    = (state == ST_PROG) || (state == ST_ERASE);
  assign hitPlane  = (rdPlane == busyPlane);
  assign hitSector = hitPlane && (rdSector == busySector);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyPlane  <= '0;
      busySector <= '0;
      lastAddr   <= '0;
      lastData   <= '0;
    end else if (strobe.loadOp) begin
      busyPlane  <= opPlane;
      busySector <= opSector;
      lastAddr   <= opAddr;
      lastData   <= opData;
    end
  end

  for (genvar gp = 0; gp < NUM_PLANES; gp++) begin : g_plane_tog
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrToggles)
        togPlane[gp] <= 1'b0;
      else if (strobe.readEvt && inBusy && hitPlane && (busyPlane == PLANE_W'(gp)))
        togPlane[gp] <= ~togPlane[gp];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrSusp)
      togSusp <= 1'b0;
    else if (strobe.readEvt && (state == ST_SUSP) && hitSector)
      togSusp <= ~togSusp;
  end

  always_comb begin
    readVal = arrayData;
    if (inBusy && hitPlane) begin
      readVal    = '0;
      readVal[6] = togPlane[rdPlane];
      readVal[7] = (state == ST_PROG) && (rdAddr == lastAddr) ? ~lastData[7] : 1'b0;
    end else if ((state == ST_SUSP) && hitSector) begin
      readVal[2] = togSusp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdData <= '0;
    else if (strobe.readEvt) rdData <= readVal;
  end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_poll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int NUM_PLANES = 4,
  parameter int SECTOR_W   = 4,
  localparam int PLANE_W   = $clog2(NUM_PLANES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opStart,
  input  logic                opErase,
  input  logic [PLANE_W-1:0]  opPlane,
  input  logic [SECTOR_W-1:0] opSector,
  input  logic [ADDR_W-1:0]   opAddr,
  input  logic [DATA_W-1:0]   opData,
  input  logic                opDone,
  input  logic                suspendReq,
  input  logic                resumeReq,
  input  logic                rdStrobe,
  input  logic [PLANE_W-1:0]  rdPlane,
  input  logic [SECTOR_W-1:0] rdSector,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   arrayData,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdyBusyOe
);
  opState_t           state;
  ctrlStrobe_t        strobe;
  logic [PLANE_W-1:0] busyPlane;
  logic [ADDR_W-1:0]  lastAddr;
  logic [DATA_W-1:0]  lastData;

  flash_poll_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opErase(opErase),
    .opDone(opDone), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .rdStrobe(rdStrobe), .state(state), .strobe(strobe), .rdyBusyOe(rdyBusyOe)
  );

  flash_poll_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PLANES(NUM_PLANES), .SECTOR_W(SECTOR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .state(state), .strobe(strobe),
    .opPlane(opPlane), .opSector(opSector), .opAddr(opAddr), .opData(opData),
    .rdPlane(rdPlane), .rdSector(rdSector), .rdAddr(rdAddr), .arrayData(arrayData),
    .rdData(rdData), .busyPlane(busyPlane), .lastAddr(lastAddr), .lastData(lastData)
  );
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk
  import flash_poll_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int PLANE_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input opState_t           state,
  input ctrlStrobe_t        strobe,
  input logic               opStart,
  input logic               opDone,
  input logic [PLANE_W-1:0] rdPlane,
  input logic [PLANE_W-1:0] busyPlane,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [ADDR_W-1:0]  lastAddr,
  input logic [DATA_W-1:0]  lastData,
  input logic [DATA_W-1:0]  arrayData,
  input logic [DATA_W-1:0]  rdData,
  input logic               rdyBusyOe
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && opStart) |=> rdyBusyOe); // R6
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PROG || state == ST_ERASE) && opDone) |=> !rdyBusyOe); // R6
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.readEvt |=> $stable(rdData)); // R8
  AST_IDLE_TRUE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && strobe.readEvt) |=> rdData == $past(arrayData)); // R5
  AST_ERASE_B7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && strobe.readEvt && rdPlane == busyPlane) |=> !rdData[7]); // R2
  AST_PROG_B7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG && strobe.readEvt && rdPlane == busyPlane && rdAddr == lastAddr)
    |=> rdData[7] != $past(lastData[7])); // R1
endmodule

bind flash_poll_status flash_poll_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PLANE_W(PLANE_W)
) chk_i (
  .clk(clk), .rstN(rstN), .state(state), .strobe(strobe), .opStart(opStart),
  .opDone(opDone), .rdPlane(rdPlane), .busyPlane(busyPlane), .rdAddr(rdAddr),
  .lastAddr(lastAddr), .lastData(lastData), .arrayData(arrayData),
  .rdData(rdData), .rdyBusyOe(rdyBusyOe)
);

// File: tb/flash_poll_status_tb.sv
module flash_poll_status_tb_top;
  localparam int DATA_W = 16, ADDR_W = 8, NUM_PLANES = 4, SECTOR_W = 4, PLANE_W = 2;

  typedef enum logic [2:0] {A_PROG, A_ERASE, A_DONE, A_SUSP, A_RES, A_READ, A_BUSY} act_t;
  typedef struct packed {
    act_t        act;
    logic [1:0]  plane;
    logic [3:0]  sector;
    logic [7:0]  addr;
    logic [15:0] data;   // loaded word for a start, array word for a read
    logic [15:0] exp;    // expected rdData, or expected rdyBusyOe in bit 0
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{A_PROG,  2'd1, 4'd2, 8'h10, 16'h1280, 16'h0000, 4'd10},
    '{A_BUSY,  2'd0, 4'd0, 8'h00, 16'h0000, 16'h0001, 4'd6},  // R6
    '{A_READ,  2'd1, 4'd0, 8'h10, 16'hA5C3, 16'h0000, 4'd7},  // R7 first read, R1
    '{A_READ,  2'd1, 4'd0, 8'h10, 16'hA5C3, 16'h0040, 4'd3},  // R3
    '{A_READ,  2'd1, 4'd0, 8'h10, 16'hA5C3, 16'h0000, 4'd3},  // R3
    '{A_READ,  2'd1, 4'd0, 8'h11, 16'hA5C3, 16'h0040, 4'd1},  // R1 other address
    '{A_READ,  2'd2, 4'd0, 8'h10, 16'hA5C3, 16'hA5C3, 4'd9},  // R9
    '{A_READ,  2'd1, 4'd0, 8'h10, 16'hA5C3, 16'h0000, 4'd9},  // R9 toggle untouched
    '{A_ERASE, 2'd3, 4'd5, 8'h20, 16'h0000, 16'h0000, 4'd10},
    '{A_READ,  2'd1, 4'd0, 8'h10, 16'hA5C3, 16'h0040, 4'd10}, // R10 still program
    '{A_DONE,  2'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd6},
    '{A_BUSY,  2'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd6},  // R6
    '{A_READ,  2'd1, 4'd0, 8'h10, 16'hA5C3, 16'hA5C3, 4'd5},  // R5
    '{A_READ,  2'd1, 4'd0, 8'h10, 16'hA5C3, 16'hA5C3, 4'd5},  // R5
    '{A_ERASE, 2'd0, 4'd3, 8'h00, 16'h0000, 16'h0000, 4'd2},
    '{A_READ,  2'd0, 4'd3, 8'h00, 16'hFFFF, 16'h0000, 4'd2},  // R2
    '{A_READ,  2'd0, 4'd7, 8'h33, 16'hFFFF, 16'h0040, 4'd2},  // R2
    '{A_SUSP,  2'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd4},
    '{A_BUSY,  2'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd6},  // R6
    '{A_READ,  2'd0, 4'd3, 8'h00, 16'h00FF, 16'h00FB, 4'd4},  // R4
    '{A_READ,  2'd0, 4'd3, 8'h00, 16'h00FF, 16'h00FF, 4'd4},  // R4
    '{A_READ,  2'd0, 4'd4, 8'h00, 16'h00FF, 16'h00FF, 4'd4},  // R4 other sector
    '{A_READ,  2'd0, 4'd3, 8'h00, 16'h00FF, 16'h00FB, 4'd4},  // R4
    '{A_RES,   2'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd6},
    '{A_BUSY,  2'd0, 4'd0, 8'h00, 16'h0000, 16'h0001, 4'd6},  // R6
    '{A_READ,  2'd0, 4'd3, 8'h00, 16'hFFFF, 16'h0000, 4'd3},  // R3 across suspend
    '{A_DONE,  2'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd5},
    '{A_READ,  2'd0, 4'd3, 8'h00, 16'h1234, 16'h1234, 4'd5},  // R5
    '{A_PROG,  2'd3, 4'd1, 8'h7F, 16'h0001, 16'h0000, 4'd1},
    '{A_READ,  2'd3, 4'd0, 8'h7F, 16'h5555, 16'h0080, 4'd1},  // R1 bit 7 clear loaded
    '{A_DONE,  2'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic opStart = 0, opErase = 0, opDone = 0, suspendReq = 0, resumeReq = 0, rdStrobe = 0;
  logic [PLANE_W-1:0]  opPlane = '0, rdPlane = '0;
  logic [SECTOR_W-1:0] opSector = '0, rdSector = '0;
  logic [ADDR_W-1:0]   opAddr = '0, rdAddr = '0;
  logic [DATA_W-1:0]   opData = '0, arrayData = '0;
  logic [DATA_W-1:0]   rdData;
  logic                rdyBusyOe;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_poll_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PLANES(NUM_PLANES),
                      .SECTOR_W(SECTOR_W)) dut_i (.*);

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doStart(input bit erase, input logic [1:0] p, input logic [3:0] s,
                         input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    opStart = 1; opErase = erase; opPlane = p; opSector = s; opAddr = a; opData = d;
    @(negedge clk);
    opStart = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    opDone = (which == 0); suspendReq = (which == 1); resumeReq = (which == 2);
    @(negedge clk);
    opDone = 0; suspendReq = 0; resumeReq = 0;
  endtask

  task automatic doRead(input logic [1:0] p, input logic [3:0] s, input logic [7:0] a,
                        input logic [15:0] d, input int holdCycles);
    @(negedge clk);
    rdStrobe = 1; rdPlane = p; rdSector = s; rdAddr = a; arrayData = d;
    repeat (holdCycles) @(negedge clk);
    rdStrobe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rdData, 16'h0000, 5);              // R5 reset value
    check({15'd0, rdyBusyOe}, 16'h0000, 6);  // R6 reset value
    rstN = 1;
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].act)
        A_PROG:  doStart(0, VECS[i].plane, VECS[i].sector, VECS[i].addr, VECS[i].data);
        A_ERASE: doStart(1, VECS[i].plane, VECS[i].sector, VECS[i].addr, VECS[i].data);
        A_DONE:  pulse(0);
        A_SUSP:  pulse(1);
        A_RES:   pulse(2);
        A_READ: begin
          doRead(VECS[i].plane, VECS[i].sector, VECS[i].addr, VECS[i].data, 1);
          check(rdData, VECS[i].exp, VECS[i].req);
        end
        default: check({15'd0, rdyBusyOe}, VECS[i].exp, VECS[i].req);
      endcase
    end
    // R8: a long-held strobe is one read; rdData holds while it stays high
    doStart(0, 2'd1, 4'd0, 8'h05, 16'h0080);
    doRead(2'd1, 4'd0, 8'h05, 16'hFFFF, 4);
    check(rdData, 16'h0000, 8);
    doRead(2'd1, 4'd0, 8'h05, 16'hFFFF, 1);
    check(rdData, 16'h0040, 8);
    @(negedge clk); arrayData = 16'h0BAD;
    @(negedge clk);
    check(rdData, 16'h0040, 8);              // R8 no read, no change
    pulse(0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule